// File: doc/BRIEF.md
# Load/Store Address Generation and Byte-Lane Unit

This block sits between the decode stage and the data memory port of a 64-bit load-store integer pipeline. For each memory request it forms a byte address from a base register value and a signed 16-bit displacement. When the displacement is zero the request is simply register-indirect. When the base register index is zero the base reads as zero, which gives absolute addressing. The address, the byte enables and the lane-steered store data are registered and presented on a memory access port one cycle after the request is accepted.

For loads, the block remembers where the item lies in the 64-bit memory word. When the returned word arrives it extracts the item, sign- or zero-extends it, and presents a register write-back one cycle later. A write-back aimed at register zero is still reported, but its write enable is held low. A mode input selects big- or little-endian lane ordering and is sampled with each request. Accesses that are not naturally aligned are flagged, and they drive no byte enables.

The unit keeps one access in flight at a time. It takes no new request while an access is waiting on the memory port or a load is waiting for its data.

Top module: `lsu_lane_unit`

## Requirements
- R1: One cycle after a request is accepted (req_valid and req_ready high at a clock edge), acc_valid is high and acc_addr equals the base value plus the 16-bit displacement sign-extended to 64 bits. A zero displacement yields the base value unchanged.
- R2: When req_base_idx is 0, the req_base input is ignored and the base is taken as zero, so acc_addr equals the sign-extended displacement.
- R3: The req_size encoding is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. Lane i is acc_be[i] and data bits [8i+7:8i]. With big_endian=0, the byte at address offset o+k (o = acc_addr[2:0]) uses lane o+k and holds item byte k, where byte 0 is least significant.
- R4: With big_endian=1, the byte at address offset o+k uses lane 7-o-k and holds item byte n-1-k, where n is the access size in bytes. The most significant byte therefore goes to the lowest address.
- R5: An access whose address is not a multiple of its size sets acc_misalign=1 with acc_be=0. A misaligned load produces no write-back and waits for no load data.
- R6: Load data is taken from the same lanes as in R3/R4. With req_unsigned=0, items of 1, 2 and 4 bytes are sign-extended to 64 bits; with req_unsigned=1 they are zero-extended. An 8-byte load is returned unchanged.
- R7: A load whose destination req_rd is 0 still raises wb_valid, but with wb_we=0. Any other destination gives wb_we=1 with wb_rd equal to the destination.
- R8: wb_valid, wb_we, wb_rd and wb_data appear one cycle after the load data is accepted (ld_valid and ld_ready high at a clock edge).
- R9: While acc_valid is high and acc_ready is low, every acc_* output holds its value and req_ready stays low. A request presented in that time is ignored.
- R10: After a load access leaves the port, req_ready stays low and ld_ready is high until the load data is accepted. After a store or misaligned access leaves the port, req_ready returns high and ld_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Lane ordering mode, sampled with each request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (0 byte .. 3 double word) |
| req_unsigned | input | 1 | Load zero-extends when set |
| req_base_idx | input | 5 | Base register index; 0 forces a zero base |
| req_base | input | 64 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 64 | Store item, right-aligned |
| req_rd | input | 5 | Load destination register index |
| acc_valid | output | 1 | Memory access present |
| acc_ready | input | 1 | Memory side takes the access |
| acc_store | output | 1 | Access is a store |
| acc_addr | output | 64 | Effective byte address |
| acc_be | output | 8 | Byte enables per lane |
| acc_wdata | output | 64 | Lane-steered store data |
| acc_misalign | output | 1 | Address not a multiple of the size |
| ld_valid | input | 1 | Load data word present |
| ld_ready | output | 1 | Unit can take load data |
| ld_data | input | 64 | Returned memory word |
| wb_valid | output | 1 | Write-back present |
| wb_ready | input | 1 | Write-back taken |
| wb_we | output | 1 | Register write enable (0 for register zero) |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Extended load result |

## Verification
Stores are driven at every size, at several aligned offsets and in both lane orders, with a data pattern whose bytes all differ. A lane swap, a wrong shift or a reversed byte order therefore shows up as a distinct wrong value. Loads use returned words whose item bytes have the top bit set and words where it is clear, in both signed and unsigned forms, which separates sign extension from zero extension and from a wrong lane pick. Addresses use positive, negative and zero displacements with both a live base and the zero base index, which separates the sign extension of the displacement from the suppression of the base. Misaligned offsets, a load to register zero and a stalled memory port cover the flag, the write suppression and the hold behaviour.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  base_idx,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base_eff;
  logic [ADDR_W-1:0] disp_ext;

  // index zero always reads as zero
  assign base_eff = (base_idx == '0) ? '0 : base;
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign addr     = base_eff + disp_ext;
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map #(
  parameter int LANES = 8
) (
  input  logic [$clog2(LANES)-1:0] ofs,
  input  lsu_pkg::size_e           size,
  input  logic                     big_endian,
  output logic [$clog2(LANES)-1:0] start,
  output logic [LANES-1:0]         mask,
  output logic                     misalign
);
  localparam int OFS_W = $clog2(LANES);
  localparam int CNT_W = OFS_W + 1;

  logic [CNT_W-1:0] nbytes;
  logic [OFS_W-1:0] low_mask;
  logic [CNT_W-1:0] start_w;

  assign nbytes   = CNT_W'(1) << size;
  assign low_mask = OFS_W'(nbytes - CNT_W'(1));
  assign misalign = (ofs & low_mask) != '0;
  // big-endian item occupies lanes mirrored around the word
  assign start_w  = big_endian ? (CNT_W'(LANES) - nbytes - {1'b0, ofs}) : {1'b0, ofs};
  assign start    = start_w[OFS_W-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = !misalign &&
                     (CNT_W'(i) >= {1'b0, start}) &&
                     (CNT_W'(i) <  ({1'b0, start} + nbytes));
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]            item,
  input  lsu_pkg::size_e               size,
  input  logic [$clog2(DATA_W/8)-1:0]  start,
  output logic [DATA_W-1:0]            lanes
);
  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = $clog2(LANES) + 1;

  logic [CNT_W-1:0]  nbytes;
  logic [DATA_W-1:0] trimmed;

  assign nbytes = CNT_W'(1) << size;

  for (genvar b = 0; b < LANES; b++) begin : g_trim
    assign trimmed[8*b +: 8] = (CNT_W'(b) < nbytes) ? item[8*b +: 8] : 8'h00;
  end

  assign lanes = trimmed << {start, 3'b000};
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0]           word,
  input  lsu_pkg::size_e              size,
  input  logic                        uns,
  input  logic [$clog2(DATA_W/8)-1:0] start,
  output logic [DATA_W-1:0]           result
);
  logic [DATA_W-1:0] shifted;

  assign shifted = word >> {start, 3'b000};

  always_comb begin
    int nbits;
    logic fill;
    nbits = 8 << size;
    fill  = uns ? 1'b0 : shifted[nbits-1];
    for (int i = 0; i < DATA_W; i++) begin
      result[i] = (i < nbits) ? shifted[i] : fill;
    end
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  big_endian,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_store,
  input  logic [1:0]            req_size,
  input  logic                  req_unsigned,
  input  logic [IDX_W-1:0]      req_base_idx,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [DISP_W-1:0]     req_disp,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [IDX_W-1:0]      req_rd,
  output logic                  acc_valid,
  input  logic                  acc_ready,
  output logic                  acc_store,
  output logic [ADDR_W-1:0]     acc_addr,
  output logic [DATA_W/8-1:0]   acc_be,
  output logic [DATA_W-1:0]     acc_wdata,
  output logic                  acc_misalign,
  input  logic                  ld_valid,
  output logic                  ld_ready,
  input  logic [DATA_W-1:0]     ld_data,
  output logic                  wb_valid,
  input  logic                  wb_ready,
  output logic                  wb_we,
  output logic [IDX_W-1:0]      wb_rd,
  output logic [DATA_W-1:0]     wb_data
);
  import lsu_pkg::*;

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);

  // request-side combinational results
  logic [ADDR_W-1:0] ea;
  logic [OFS_W-1:0]  lane_start;
  logic [LANES-1:0]  lane_mask;
  logic              mis;
  logic [DATA_W-1:0] steered;
  size_e             sz;

  assign sz = size_e'(req_size);

  lsu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W)) u_agen (
    .base_idx (req_base_idx),
    .base     (req_base),
    .disp     (req_disp),
    .addr     (ea)
  );

  lsu_lane_map #(.LANES(LANES)) u_map (
    .ofs        (ea[OFS_W-1:0]),
    .size       (sz),
    .big_endian (big_endian),
    .start      (lane_start),
    .mask       (lane_mask),
    .misalign   (mis)
  );

  lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
    .item  (req_wdata),
    .size  (sz),
    .start (lane_start),
    .lanes (steered)
  );

  // state
  logic              acc_valid_q, acc_store_q, acc_mis_q, acc_is_load_q;
  logic [ADDR_W-1:0] acc_addr_q;
  logic [LANES-1:0]  acc_be_q;
  logic [DATA_W-1:0] acc_wdata_q;
  size_e             acc_size_q;
  logic              pend_q;
  logic [OFS_W-1:0]  ctx_start_q;
  size_e             ctx_size_q;
  logic              ctx_uns_q;
  logic [IDX_W-1:0]  ctx_rd_q;
  logic              wb_valid_q, wb_we_q;
  logic [IDX_W-1:0]  wb_rd_q;
  logic [DATA_W-1:0] wb_data_q;
  logic [DATA_W-1:0] aligned;

  lsu_load_align #(.DATA_W(DATA_W)) u_align (
    .word   (ld_data),
    .size   (ctx_size_q),
    .uns    (ctx_uns_q),
    .start  (ctx_start_q),
    .result (aligned)
  );

  logic req_fire, acc_fire, ld_fire, wb_fire;

  assign req_ready = !acc_valid_q && !pend_q;
  assign ld_ready  = pend_q && (!wb_valid_q || wb_ready);
  assign req_fire  = req_valid && req_ready;
  assign acc_fire  = acc_valid_q && acc_ready;
  assign ld_fire   = ld_valid && ld_ready;
  assign wb_fire   = wb_valid_q && wb_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid_q   <= 1'b0;
      acc_store_q   <= 1'b0;
      acc_mis_q     <= 1'b0;
      acc_is_load_q <= 1'b0;
      acc_addr_q    <= '0;
      acc_be_q      <= '0;
      acc_wdata_q   <= '0;
      acc_size_q    <= SZ_BYTE;
      pend_q        <= 1'b0;
      ctx_start_q   <= '0;
      ctx_size_q    <= SZ_BYTE;
      ctx_uns_q     <= 1'b0;
      ctx_rd_q      <= '0;
      wb_valid_q    <= 1'b0;
      wb_we_q       <= 1'b0;
      wb_rd_q       <= '0;
      wb_data_q     <= '0;
    end else begin
      if (req_fire) begin
        acc_valid_q   <= 1'b1;
        acc_store_q   <= req_store;
        acc_mis_q     <= mis;
        acc_is_load_q <= !req_store && !mis;
        acc_addr_q    <= ea;
        acc_be_q      <= lane_mask;
        acc_wdata_q   <= (req_store && !mis) ? steered : '0;
        acc_size_q    <= sz;
        ctx_start_q   <= lane_start;
        ctx_size_q    <= sz;
        ctx_uns_q     <= req_unsigned;
        ctx_rd_q      <= req_rd;
      end else if (acc_fire) begin
        acc_valid_q <= 1'b0;
        if (acc_is_load_q) pend_q <= 1'b1;
      end

      if (ld_fire) begin
        pend_q     <= 1'b0;
        wb_valid_q <= 1'b1;
        wb_we_q    <= (ctx_rd_q != '0);
        wb_rd_q    <= ctx_rd_q;
        wb_data_q  <= aligned;
      end else if (wb_fire) begin
        wb_valid_q <= 1'b0;
      end
    end
  end

  assign acc_valid    = acc_valid_q;
  assign acc_store    = acc_store_q;
  assign acc_addr     = acc_addr_q;
  assign acc_be       = acc_be_q;
  assign acc_wdata    = acc_wdata_q;
  assign acc_misalign = acc_mis_q;
  assign wb_valid     = wb_valid_q;
  assign wb_we        = wb_we_q;
  assign wb_rd        = wb_rd_q;
  assign wb_data      = wb_data_q;

  // R3/R4: aligned access enables exactly its size in lanes
  p_be_count_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_misalign) |-> ($countones(acc_be) == (1 << acc_size_q)));

  // R5: misaligned access drives no lanes
  p_misalign_no_be_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_misalign) |-> (acc_be == '0));

  // R6: unsigned narrow loads leave upper bits clear
  p_zext_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_fire && ctx_uns_q && ctx_size_q != SZ_DWORD) |=>
      ((wb_data >> (8 << $past(ctx_size_q))) == '0));

  // R7: register zero never written
  p_no_write_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && wb_rd == '0) |-> !wb_we);

  // R9: stalled access holds
  p_acc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_ready) |=>
      (acc_valid && $stable(acc_addr) && $stable(acc_be) && $stable(acc_wdata)));

  // R10: one access in flight
  p_single_flight_r10: assert property (@(posedge clk) disable iff (rst)
    (ld_ready || acc_valid) |-> !req_ready);

  // R8: write-back holds until taken
  p_wb_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && $stable(wb_rd)));
endmodule

// File: tb/lsu_lane_unit_tb.sv
module lsu_lane_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_unsigned = 1'b0;
  logic [4:0]  req_base_idx = 5'd0;
  logic [63:0] req_base = '0;
  logic [15:0] req_disp = '0;
  logic [63:0] req_wdata = '0;
  logic [4:0]  req_rd = 5'd0;
  logic        acc_valid;
  logic        acc_ready = 1'b0;
  logic        acc_store;
  logic [63:0] acc_addr;
  logic [7:0]  acc_be;
  logic [63:0] acc_wdata;
  logic        acc_misalign;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [63:0] ld_data = '0;
  logic        wb_valid;
  logic        wb_ready = 1'b0;
  logic        wb_we;
  logic [4:0]  wb_rd;
  logic [63:0] wb_data;

  int total = 0;
  int failed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsu_lane_unit u_dut (
    .clk(clk), .rst(rst), .big_endian(big_endian),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base_idx(req_base_idx),
    .req_base(req_base), .req_disp(req_disp), .req_wdata(req_wdata), .req_rd(req_rd),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_store(acc_store),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_misalign(acc_misalign), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_we(wb_we),
    .wb_rd(wb_rd), .wb_data(wb_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // byte-level reference from the requirements
  function automatic int lane_of(int o, int k, bit be);
    return be ? 7 - o - k : o + k;
  endfunction

  function automatic int item_byte(int n, int k, bit be);
    return be ? n - 1 - k : k;
  endfunction

  function automatic logic [7:0] exp_be(int o, int sz, bit be);
    int n = 1 << sz;
    logic [7:0] m = '0;
    if (o % n != 0) return 8'h00;
    for (int k = 0; k < n; k++) m[lane_of(o, k, be)] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] exp_wd(int o, int sz, bit be, logic [63:0] d);
    int n = 1 << sz;
    logic [63:0] w = '0;
    for (int k = 0; k < n; k++) w[8*lane_of(o, k, be) +: 8] = d[8*item_byte(n, k, be) +: 8];
    return w;
  endfunction

  function automatic logic [63:0] exp_ld(int o, int sz, bit be, bit uns, logic [63:0] word);
    int n = 1 << sz;
    logic [63:0] it = '0;
    for (int k = 0; k < n; k++) it[8*item_byte(n, k, be) +: 8] = word[8*lane_of(o, k, be) +: 8];
    if (!uns && n < 8 && it[8*n-1])
      for (int b = 8*n; b < 64; b++) it[b] = 1'b1;
    return it;
  endfunction

  task automatic issue(input bit st, input int sz, input bit uns, input bit be,
                       input logic [4:0] bidx, input logic [63:0] base,
                       input logic [15:0] disp, input logic [63:0] wd, input logic [4:0] rd);
    @(negedge clk);
    req_store = st; req_size = 2'(sz); req_unsigned = uns; big_endian = be;
    req_base_idx = bidx; req_base = base; req_disp = disp; req_wdata = wd; req_rd = rd;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic consume_acc();
    acc_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_ready = 1'b0;
  endtask

  task automatic return_word(input logic [63:0] w);
    ld_valid = 1'b1; ld_data = w;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic drain_wb();
    wb_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wb_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("reset acc_valid", 64'(acc_valid), 64'd0);
    chk("reset wb_valid", 64'(wb_valid), 64'd0);
    chk("reset req_ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_address();
    issue(1'b0, 3, 1'b0, 1'b0, 5'd4, 64'h0000_1000_0000_0100, 16'h0040, '0, 5'd3);
    chk("R1 positive disp", acc_addr, 64'h0000_1000_0000_0140);
    chk("R1 acc_valid", 64'(acc_valid), 64'd1);
    consume_acc(); return_word('0); drain_wb();
    issue(1'b0, 3, 1'b0, 1'b0, 5'd4, 64'h0000_1000_0000_0100, 16'hFFF0, '0, 5'd3);
    chk("R1 negative disp", acc_addr, 64'h0000_1000_0000_00F0);
    consume_acc(); return_word('0); drain_wb();
    issue(1'b1, 3, 1'b0, 1'b0, 5'd9, 64'h0000_0000_ABCD_0008, 16'h0000, '0, 5'd0);
    chk("R1 zero disp indirect", acc_addr, 64'h0000_0000_ABCD_0008);
    consume_acc();
    issue(1'b1, 3, 1'b0, 1'b0, 5'd0, 64'hDEAD_BEEF_0000_0000, 16'h8000, '0, 5'd0);
    chk("R2 absolute neg", acc_addr, 64'hFFFF_FFFF_FFFF_8000);
    consume_acc();
    issue(1'b1, 3, 1'b0, 1'b0, 5'd0, 64'h1234_5678_9ABC_DEF0, 16'h7FF8, '0, 5'd0);
    chk("R2 absolute pos", acc_addr, 64'h0000_0000_0000_7FF8);
    consume_acc();
  endtask

  task automatic t_stores();
    logic [63:0] d = 64'h8877_6655_4433_2211;
    int offs[4] = '{5, 6, 4, 0};
    for (int be = 0; be < 2; be++) begin
      for (int sz = 0; sz < 4; sz++) begin
        int o = offs[sz];
        issue(1'b1, sz, 1'b0, be[0], 5'd2, 64'h100, 16'(o), d, 5'd0);
        chk(be ? "R4 store be" : "R3 store be", 64'(acc_be), 64'(exp_be(o, sz, be[0])));
        chk(be ? "R4 store data" : "R3 store data", acc_wdata, exp_wd(o, sz, be[0], d));
        chk("R5 aligned flag", 64'(acc_misalign), 64'd0);
        consume_acc();
        chk("R10 ready after store", 64'(req_ready), 64'd1);
        chk("R10 no ld_ready after store", 64'(ld_ready), 64'd0);
      end
    end
  endtask

  task automatic t_misalign();
    int cases[3][2] = '{'{1, 1}, '{2, 2}, '{3, 4}};
    foreach (cases[i]) begin
      issue(1'b1, cases[i][0], 1'b0, 1'b0, 5'd2, 64'h200, 16'(cases[i][1]), '1, 5'd0);
      chk("R5 misalign flag", 64'(acc_misalign), 64'd1);
      chk("R5 misalign be", 64'(acc_be), 64'd0);
      consume_acc();
    end
    issue(1'b0, 2, 1'b0, 1'b1, 5'd2, 64'h200, 16'd6, '0, 5'd7);
    chk("R5 misaligned load flag", 64'(acc_misalign), 64'd1);
    consume_acc();
    chk("R5 misaligned load no ld_ready", 64'(ld_ready), 64'd0);
    chk("R5 misaligned load req_ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk("R5 misaligned load no wb", 64'(wb_valid), 64'd0);
  endtask

  task automatic t_loads();
    logic [63:0] w1 = 64'hF1E2_D3C4_B5A6_9788;
    logic [63:0] w2 = 64'h0172_6354_4536_2718;
    int offs[4] = '{3, 2, 4, 0};
    for (int be = 0; be < 2; be++)
      for (int sz = 0; sz < 4; sz++)
        for (int uns = 0; uns < 2; uns++)
          for (int p = 0; p < 2; p++) begin
            logic [63:0] w = p ? w2 : w1;
            int o = offs[sz];
            issue(1'b0, sz, uns[0], be[0], 5'd6, 64'h300, 16'(o), '0, 5'd12);
            consume_acc();
            chk("R10 ld_ready pending", 64'(ld_ready), 64'd1);
            chk("R10 req_ready low pending", 64'(req_ready), 64'd0);
            return_word(w);
            chk("R8 wb_valid", 64'(wb_valid), 64'd1);
            chk("R6 load data", wb_data, exp_ld(o, sz, be[0], uns[0], w));
            chk("R7 wb_we", 64'(wb_we), 64'd1);
            chk("R7 wb_rd", 64'(wb_rd), 64'd12);
            drain_wb();
          end
  endtask

  task automatic t_rd_zero();
    issue(1'b0, 3, 1'b0, 1'b0, 5'd1, 64'h400, 16'd0, '0, 5'd0);
    consume_acc();
    return_word(64'hCAFE_F00D_1234_5678);
    chk("R7 wb_valid rd0", 64'(wb_valid), 64'd1);
    chk("R7 wb_we rd0", 64'(wb_we), 64'd0);
    drain_wb();
  endtask

  task automatic t_stall();
    issue(1'b1, 2, 1'b0, 1'b0, 5'd3, 64'h500, 16'd4, 64'h0000_0000_A1B2_C3D4, 5'd0);
    req_valid = 1'b1; req_base = 64'h9999_0000; req_disp = 16'd0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R9 held addr", acc_addr, 64'h504);
      chk("R9 held data", acc_wdata, 64'hA1B2_C3D4_0000_0000);
      chk("R9 req_ready low", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    consume_acc();
    chk("R9 stalled request dropped", 64'(acc_valid), 64'd0);
    // write-back hold under wb_ready low
    issue(1'b0, 1, 1'b1, 1'b1, 5'd3, 64'h500, 16'd2, '0, 5'd9);
    consume_acc();
    return_word(64'h0000_BEEF_0000_0000);
    @(negedge clk);
    chk("R8 wb held", wb_data, 64'h0000_0000_0000_BEEF);
    chk("R8 wb held valid", 64'(wb_valid), 64'd1);
    drain_wb();
    chk("R8 wb drained", 64'(wb_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_address();
    t_stores();
    t_misalign();
    t_loads();
    t_rd_zero();
    t_stall();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule